// File: doc/BRIEF.md
# Idle-Adaptive Scaled Timestamp Generator

This block sits in a trace message path and stamps each incoming message with a time value and a granularity code. A free-running clock count advances every cycle. The stamp for a message is that count shifted right by the current granularity exponent. The exponent travels with the stamp so that a downstream decoder can rebuild absolute time.

While no message arrives, the granularity grows coarser on its own. Each idle window lasts 2^(IDLE_LOG + k) cycles, where k is the current exponent. With the default IDLE_LOG of 8, the finest level holds for 256 cycles. When a window expires, k goes up by one while it is below STEP_EXP, and by two once it has reached STEP_EXP. It never goes past MAX_EXP. With the defaults the exponent runs through 0, 1, 2, 3, 4, 5, 6, 8, 10 and so on up to 24.

A message always reports the exponent that was in effect on its own cycle. The cycle after a message, the granularity returns to the finest level. Payload formatting, serialisation and storage belong to other blocks.

Top module: `idle_scaled_stamp`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears itself. After that edge `count_o` is 0, `stamp_valid_o` is 0, `stamp_exp_o` is 0 and the granularity exponent is 0.
- R2: After reset, `count_o` increases by exactly one on every clock edge and wraps modulo 2^CNT_W.
- R3: A message that arrives when fewer than 2^IDLE_LOG cycles have passed since the last message or reset is stamped with exponent 0.
- R4: With exponent k below STEP_EXP, if 2^(IDLE_LOG+k) consecutive cycles pass without a message, the exponent becomes k+1.
- R5: With exponent k at or above STEP_EXP, if 2^(IDLE_LOG+k) cycles pass without a message, the exponent becomes k+2, clamped to MAX_EXP.
- R6: The exponent never exceeds MAX_EXP and stays there while no message arrives.
- R7: Let a message be sampled on the edge where the count is c and the exponent is e. On the next cycle `stamp_valid_o` is 1, `stamp_o` equals c >> e, and `stamp_exp_o` equals e as an unsigned 5-bit field. `stamp_valid_o` is 0 in every cycle that does not follow a message.
- R8: A message on the last cycle of an idle window is stamped with the exponent in effect before that step.
- R9: After any message the exponent is 0 again. A later message with a short gap is stamped with exponent 0.
- R10: A reset in the middle of an idle period restores the finest granularity and restarts the count from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| msg_i | input | 1 | Message present on this cycle |
| count_o | output | CNT_W | Free-running cycle count |
| stamp_valid_o | output | 1 | Stamp outputs hold a new message stamp |
| stamp_o | output | CNT_W | Count shifted right by the stamp's exponent |
| stamp_exp_o | output | 5 | Granularity exponent of the stamp |

## Verification
The bench walks a table of idle gaps. Each boundary of the exponent sequence gets a message on the last cycle of its window and another on the first cycle past it. An off-by-one in the window compare would stamp one of each pair with the wrong exponent. A missing switch to double steps would produce exponents such as 5 or 7. A wrong clamp would push the exponent past its ceiling on the longest gap. Further tests repeat a short-gap message right after the coarsest stamp and reset in the middle of an idle stretch. These catch a design that forgets to drop back to the finest level, and their stamp values expose a shift taken from the wrong exponent or a stamp taken one cycle late.

// File: rtl/idle_scaled_stamp.sv
module idle_scaled_stamp #(
  parameter int CNT_W    = 32,
  parameter int IDLE_LOG = 8,
  parameter int STEP_EXP = 6,
  parameter int MAX_EXP  = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             msg_i,
  output logic [CNT_W-1:0] count_o,
  output logic             stamp_valid_o,
  output logic [CNT_W-1:0] stamp_o,
  output logic [4:0]       stamp_exp_o
);
  localparam int IW = IDLE_LOG + MAX_EXP + 1;
  localparam logic [4:0] MAX_E  = 5'(MAX_EXP);
  localparam logic [4:0] STEP_E = 5'(STEP_EXP);
  localparam logic [5:0] MAX_E6 = 6'(MAX_EXP);

  logic [4:0]    gran_q;
  logic [IW-1:0] idle_q;
  logic [IW-1:0] win_last;
  logic [5:0]    bump;
  logic [4:0]    gran_nxt;

  assign win_last = ({{(IW-1){1'b0}}, 1'b1} << (IDLE_LOG + int'(gran_q))) - 1'b1;
  assign bump     = {1'b0, gran_q} + ((gran_q >= STEP_E) ? 6'd2 : 6'd1);
  assign gran_nxt = (bump > MAX_E6) ? MAX_E : bump[4:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o       <= '0;
      gran_q        <= '0;
      idle_q        <= '0;
      stamp_valid_o <= 1'b0;
      stamp_o       <= '0;
      stamp_exp_o   <= '0;
    end else begin
      count_o       <= count_o + 1'b1;
      stamp_valid_o <= msg_i;
      if (msg_i) begin
        stamp_o     <= count_o >> gran_q;
        stamp_exp_o <= gran_q;
        gran_q      <= '0;
        idle_q      <= '0;
      end else if (gran_q == MAX_E) begin
        idle_q      <= '0;
      end else if (idle_q == win_last) begin
        gran_q      <= gran_nxt;
        idle_q      <= '0;
      end else begin
        idle_q      <= idle_q + 1'b1;
      end
    end
  end
endmodule

module idle_scaled_stamp_chk #(
  parameter int CNT_W    = 32,
  parameter int STEP_EXP = 6,
  parameter int MAX_EXP  = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             msg_i,
  input logic [4:0]       gran,
  input logic [CNT_W-1:0] count_o,
  input logic             stamp_valid_o,
  input logic [4:0]       stamp_exp_o
);
  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> count_o == $past(count_o) + 1'b1);

  assert_valid_follows_msg_R7: assert property (@(posedge clk) disable iff (rst)
    stamp_valid_o |-> $past(msg_i));

  assert_msg_gives_valid_R7: assert property (@(posedge clk) disable iff (rst)
    msg_i |=> stamp_valid_o);

  assert_exp_ceiling_R6: assert property (@(posedge clk) disable iff (rst)
    (int'(gran) <= MAX_EXP) && (int'(stamp_exp_o) <= MAX_EXP));

  assert_msg_restores_fine_R9: assert property (@(posedge clk) disable iff (rst)
    msg_i |=> gran == 5'd0);

  assert_idle_step_size_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(msg_i) && gran != $past(gran) && int'($past(gran)) < STEP_EXP)
      |-> gran == $past(gran) + 5'd1);

  assert_idle_step_size_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(msg_i) && gran != $past(gran) && int'($past(gran)) >= STEP_EXP)
      |-> (gran == $past(gran) + 5'd2 || int'(gran) == MAX_EXP));
endmodule

bind idle_scaled_stamp idle_scaled_stamp_chk #(
  .CNT_W(CNT_W), .STEP_EXP(STEP_EXP), .MAX_EXP(MAX_EXP)
) u_chk (
  .clk(clk), .rst(rst), .msg_i(msg_i), .gran(gran_q),
  .count_o(count_o), .stamp_valid_o(stamp_valid_o), .stamp_exp_o(stamp_exp_o)
);

// File: tb/test_idle_scaled_stamp.sv
module test_idle_scaled_stamp;
  localparam int PERIOD = 10;
  localparam int CW = 16;
  localparam int NV = 18;
  // idle cycles before each message, and the exponent expected
  // (IDLE_LOG=2, STEP_EXP=4, MAX_EXP=10: window ends at 4,12,28,60,124,380,1404)
  localparam int GAP[NV]  = '{0, 3, 4, 11, 12, 27, 28, 59, 60, 123, 124, 379, 380, 1403, 1404, 2000, 1, 0};
  localparam int EXPV[NV] = '{0, 0, 1, 1,  2,  2,  3,  3,  4,  4,   6,   6,   8,   8,    10,   10,   0, 0};

  logic clk = 0, rst = 1, msg = 0;
  logic [CW-1:0] count, stamp;
  logic valid;
  logic [4:0] sexp;
  int n_chk = 0, n_ok = 0;
  int t = 0;

  always #(PERIOD/2) clk = ~clk;

  idle_scaled_stamp #(.CNT_W(CW), .IDLE_LOG(2), .STEP_EXP(4), .MAX_EXP(10)) i_idle_scaled_stamp (
    .clk(clk), .rst(rst), .msg_i(msg), .count_o(count),
    .stamp_valid_o(valid), .stamp_o(stamp), .stamp_exp_o(sexp));

  task automatic check(string req, int act, int expv);
    n_chk++;
    if (act == expv) n_ok++;
    else $display("FAIL %s: actual %0d expected %0d (t=%0d)", req, act, expv, t);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      msg = 0; @(posedge clk); @(negedge clk); t++;
    end
  endtask

  task automatic send(int e, string req);
    int m;
    msg = 1; m = t;
    @(posedge clk); @(negedge clk); t++;
    msg = 0;
    check({req, " valid"}, int'(valid), 1);
    check({req, " exponent"}, int'(sexp), e);
    check({req, " stamp"}, int'(stamp), int'(CW'(m >> e)));
    check("R2 count", int'(count), t % (1 << CW));
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_ok, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 count", int'(count), 0);
    check("R1 valid", int'(valid), 0);
    check("R1 exponent", int'(sexp), 0);
    rst = 0;
    t = 0;

    for (int v = 0; v < NV; v++) begin
      idle(GAP[v]);
      if (GAP[v] > 0) check("R7 no valid while idle", int'(valid), 0);
      if (v == 0 || v == 1) send(EXPV[v], "R3");
      else if (v >= NV - 2) send(EXPV[v], "R9");
      else if (v >= 14) send(EXPV[v], "R6");
      else if ((v % 2) == 1) send(EXPV[v], "R8");
      else if (EXPV[v] > 4) send(EXPV[v], "R5");
      else send(EXPV[v], "R4");
    end

    idle(5);
    check("R7 single-cycle valid", int'(valid), 0);
    check("R2 count after idle", int'(count), t);

    idle(95);
    rst = 1;
    @(posedge clk); @(negedge clk);
    rst = 0;
    t = 0;
    check("R10 count restarts", int'(count), 0);
    check("R10 valid cleared", int'(valid), 0);
    send(0, "R10");
    idle(2);
    send(0, "R10 short gap");

    $display("%0d/%0d checks passed", n_ok, n_chk);
    $finish;
  end
endmodule